// File: doc/BRIEF.md
# Offset-Coded Programmable Clock Divider

This block produces a slower clock from its input clock, dividing by an integer ratio that software or neighbouring logic can change while the block is running. The ratio is given as a 10-bit code with a fixed offset of two added to it. An all-zero code therefore divides by 2, and the all-ones code divides by 1025. Because of the offset, no code value can select a ratio of 0 or 1.

A new code is presented together with a one-cycle load strobe. The code is held in a pending register and is applied only when the running period ends. The output period in progress always completes at its old length, so no short or runt pulse can appear. For even ratios the output is high for exactly half the period. For odd ratios a falling-edge stage pulls the output low half an input cycle early, which gives an exact 50% duty cycle. A one-cycle wrap pulse marks the last input cycle of every output period.

Top module: `prog_clk_div`

## Requirements
- R1: A synchronous reset clears both outputs to 0 and selects code 0, so the ratio after reset is 2. The wrap pulses that follow reset come 2 cycles apart.
- R2: The ratio N equals the active code plus 2. Code 1 gives 3 and code 1023 (all ones) gives 1025, so consecutive wrap pulses are N input cycles apart.
- R3: For even N, each period starts with N/2 input cycles of low output, followed by N/2 input cycles of high output. The rise comes at the start of cycle N/2, counted from 0 at the period start.
- R4: For odd N, the output rises at the start of cycle (N-1)/2 of the period and falls in the middle of cycle N-1, while the input clock is low. It is therefore high for N/2 input cycles exactly.
- R5: The wrap pulse is high for exactly one input cycle per period, and that cycle is the last one (cycle N-1).
- R6: A code loaded in the middle of a period does not change that period. The period completes with the old N, and the new N applies from the next period.
- R7: A code loaded in the last cycle of a period (the cycle in which the wrap pulse is high) governs the period that begins at the following clock edge.
- R8: If more than one code is loaded within a single period, the last code loaded is the one applied at the next period boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous reset, active high |
| div_code | input | 10 | Ratio code; ratio = code + 2 |
| div_load | input | 1 | One-cycle strobe that captures div_code |
| clk_div_o | output | 1 | Divided clock output |
| wrap_pulse_o | output | 1 | High during the last input cycle of each output period |

## Verification
Two functions can fall in the same cycle: capturing a load strobe and ending a period. The bench provokes this case by watching its own model. When the model shows the counter in its last cycle, the bench raises the load strobe in that cycle. The distance from that period edge to the next wrap pulse is then judged, and it must match the freshly loaded ratio, not the pending one. Separately, a mid-period load must leave the length of the current period unchanged.

// File: rtl/prog_clk_div_pkg.sv
package prog_clk_div_pkg;
   // Width of a counter able to hold the largest ratio
   function automatic int unsigned cnt_width(input int unsigned code_w);
      return code_w + 2;
   endfunction

   // Largest ratio reachable with the given code width and offset
   function automatic int unsigned max_ratio(input int unsigned code_w,
                                             input int unsigned offset);
      return (32'd1 << code_w) - 1 + offset;
   endfunction
endpackage

// File: rtl/pcd_ratio_hold.sv
module pcd_ratio_hold #(
   parameter int unsigned CODE_W   = 10,
   parameter int unsigned RST_CODE = 0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load_i,
   input  logic [CODE_W-1:0] code_i,
   input  logic              wrap_i,
   output logic [CODE_W-1:0] active_o
);
   logic [CODE_W-1:0] pend_q;
   logic [CODE_W-1:0] act_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         pend_q <= CODE_W'(RST_CODE);
         act_q  <= CODE_W'(RST_CODE);
      end else begin
         if (load_i) pend_q <= code_i;
         // a strobe coinciding with the boundary bypasses the pending copy
         if (wrap_i) act_q <= load_i ? code_i : pend_q;
      end
   end

   assign active_o = act_q;
endmodule

// File: rtl/pcd_count.sv
module pcd_count #(
   parameter int unsigned CODE_W = 10,
   parameter int unsigned OFFSET = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [CODE_W-1:0] active_i,
   output logic              wrap_o,
   output logic              hi_o,
   output logic              tc_o,
   output logic              odd_o
);
   import prog_clk_div_pkg::*;
   localparam int unsigned CNT_W = cnt_width(CODE_W);

   logic [CNT_W-1:0] cnt_q, cnt_d, last_c, half_c;
   logic             hi_q, hi_d, tc_q, tc_d;

   always_comb begin
      last_c = CNT_W'(active_i) + CNT_W'(OFFSET - 1);
      half_c = (CNT_W'(active_i) + CNT_W'(OFFSET)) >> 1;
      wrap_o = (cnt_q == last_c);
      cnt_d  = wrap_o ? '0 : cnt_q + 1'b1;
      hi_d   = !wrap_o && (cnt_d >= half_c);
      tc_d   = !wrap_o && (cnt_d == last_c);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
         hi_q  <= 1'b0;
         tc_q  <= 1'b0;
      end else begin
         cnt_q <= cnt_d;
         hi_q  <= hi_d;
         tc_q  <= tc_d;
      end
   end

   assign hi_o  = hi_q;
   assign tc_o  = tc_q;
   // parity of code + OFFSET
   assign odd_o = active_i[0] ^ OFFSET[0];
endmodule

// File: rtl/pcd_duty.sv
module pcd_duty #(
   parameter bit ODD_FIX = 1'b1
) (
   input  logic clk,
   input  logic hi_i,
   input  logic tc_i,
   input  logic odd_i,
   output logic out_o
);
   generate
      if (ODD_FIX) begin : g_halfcut
         logic cut_n;
         // falling-edge stage trims the last half cycle of an odd period
         always_ff @(negedge clk) cut_n <= tc_i & odd_i;
         assign out_o = hi_i & ~cut_n;
      end else begin : g_plain
         logic unused_c;
         assign unused_c = tc_i ^ odd_i;
         assign out_o    = hi_i;
      end
   endgenerate
endmodule

// File: rtl/prog_clk_div.sv
module prog_clk_div #(
   parameter int unsigned CODE_W   = 10,
   parameter int unsigned OFFSET   = 2,
   parameter int unsigned RST_CODE = 0,
   parameter bit          ODD_FIX  = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [CODE_W-1:0] div_code,
   input  logic              div_load,
   output logic              clk_div_o,
   output logic              wrap_pulse_o
);
   generate
      if (CODE_W < 1 || CODE_W > 28) begin : g_bad_width
         $error("prog_clk_div: CODE_W out of range");
      end
      if (OFFSET < 2) begin : g_bad_offset
         $error("prog_clk_div: OFFSET must be at least 2");
      end
      if (RST_CODE >= (32'd1 << CODE_W)) begin : g_bad_rst
         $error("prog_clk_div: RST_CODE does not fit CODE_W");
      end
   endgenerate

   logic [CODE_W-1:0] active_c;
   logic              wrap_c, hi_c, tc_c, odd_c;

   pcd_ratio_hold #(.CODE_W(CODE_W), .RST_CODE(RST_CODE)) u_hold (
      .clk(clk), .rst(rst), .load_i(div_load), .code_i(div_code),
      .wrap_i(wrap_c), .active_o(active_c)
   );

   pcd_count #(.CODE_W(CODE_W), .OFFSET(OFFSET)) u_count (
      .clk(clk), .rst(rst), .active_i(active_c), .wrap_o(wrap_c),
      .hi_o(hi_c), .tc_o(tc_c), .odd_o(odd_c)
   );

   pcd_duty #(.ODD_FIX(ODD_FIX)) u_duty (
      .clk(clk), .hi_i(hi_c), .tc_i(tc_c), .odd_i(odd_c), .out_o(clk_div_o)
   );

   assign wrap_pulse_o = tc_c;
endmodule

// File: rtl/prog_clk_div_chk.sv
module prog_clk_div_chk #(
   parameter int unsigned CODE_W = 10,
   parameter int unsigned OFFSET = 2
) (
   input logic clk,
   input logic rst,
   input logic clk_div_o,
   input logic wrap_pulse_o
);
   import prog_clk_div_pkg::*;
   localparam int unsigned MAXN = max_ratio(CODE_W, OFFSET);

   int unsigned gap_q;
   logic        seen_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         gap_q  <= 0;
         seen_q <= 1'b0;
      end else if (wrap_pulse_o) begin
         gap_q  <= 1;
         seen_q <= 1'b1;
      end else begin
         gap_q  <= gap_q + 1;
      end
   end

   // R1
   reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!clk_div_o && !wrap_pulse_o));

   // R5
   single_wrap_chk: assert property (@(posedge clk) disable iff (rst)
      wrap_pulse_o |=> !wrap_pulse_o);

   // R3
   low_start_chk: assert property (@(posedge clk) disable iff (rst)
      wrap_pulse_o |=> !clk_div_o);

   // R2
   period_range_chk: assert property (@(posedge clk) disable iff (rst)
      (seen_q && wrap_pulse_o) |-> (gap_q >= OFFSET && gap_q <= MAXN));
endmodule

bind prog_clk_div prog_clk_div_chk #(.CODE_W(CODE_W), .OFFSET(OFFSET)) u_chk (
   .clk(clk), .rst(rst), .clk_div_o(clk_div_o), .wrap_pulse_o(wrap_pulse_o)
);

// File: tb/tb_prog_clk_div.sv
`timescale 1ns/1ps
module tb_prog_clk_div;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [9:0] div_code = '0;
   logic       div_load = 1'b0;
   logic       clk_div_o, wrap_pulse_o;

   int vectors = 0;
   int fails   = 0;
   int cyc     = 0;
   int r_cnt = 0, r_n = 2, r_pend = 0;
   bit r_ok = 1'b0;

   always #2.5 clk = ~clk;

   prog_clk_div dut (
      .clk(clk), .rst(rst), .div_code(div_code), .div_load(div_load),
      .clk_div_o(clk_div_o), .wrap_pulse_o(wrap_pulse_o)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d cycle=%0d", tag, act, exp, cyc);
      end
   endtask

   // behavioural reference, compared twice per input cycle
   always @(posedge clk) begin
      bit exp_hi, exp_tc, exp_lo_half;
      cyc++;
      if (rst) begin
         r_cnt = 0; r_n = 2; r_pend = 0; r_ok = 1'b1;
      end else if (r_ok) begin
         if (div_load) r_pend = int'(div_code);
         if (r_cnt == r_n - 1) begin
            r_n = r_pend + 2;
            r_cnt = 0;
         end else begin
            r_cnt++;
         end
      end
      if (r_ok) begin
         #1;
         exp_tc = (r_cnt == r_n - 1);
         exp_hi = (r_cnt >= r_n / 2);
         chk(wrap_pulse_o == exp_tc, "R5 wrap pulse", int'(wrap_pulse_o), int'(exp_tc));
         chk(clk_div_o == exp_hi, (r_n % 2) ? "R4 first half" : "R3 first half",
             int'(clk_div_o), int'(exp_hi));
         #2.5;
         exp_lo_half = exp_hi && !((r_n % 2 == 1) && exp_tc);
         chk(clk_div_o == exp_lo_half, (r_n % 2) ? "R4 second half" : "R3 second half",
             int'(clk_div_o), int'(exp_lo_half));
      end
   end

   task automatic wait_tc();
      do begin
         @(posedge clk); #1;
      end while (!wrap_pulse_o);
   endtask

   task automatic load_code(input int code);
      @(posedge clk); #2;
      div_code = 10'(code);
      div_load = 1'b1;
      @(posedge clk); #2;
      div_load = 1'b0;
   endtask

   task automatic expect_period(input int exp, input string tag);
      int c0;
      wait_tc();
      c0 = cyc;
      wait_tc();
      chk(cyc - c0 == exp, tag, cyc - c0, exp);
   endtask

   initial begin
      #(200000 * 5);
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      int c0;
      repeat (3) @(posedge clk);
      #2 rst = 1'b0;
      #0.5;
      // R1: outputs low right after reset
      chk(clk_div_o == 1'b0, "R1 output low after reset", int'(clk_div_o), 0);
      chk(wrap_pulse_o == 1'b0, "R1 wrap low after reset", int'(wrap_pulse_o), 0);
      expect_period(2, "R1 default ratio 2");

      load_code(1);
      expect_period(3, "R2 code 1 gives 3");
      load_code(2);
      expect_period(4, "R3 code 2 gives 4");
      load_code(3);
      expect_period(5, "R4 code 3 gives 5");

      // R6: mid-period load keeps the current period length
      wait_tc();
      c0 = cyc;
      load_code(8);
      wait_tc();
      chk(cyc - c0 == 5, "R6 old period kept", cyc - c0, 5);
      c0 = cyc;
      wait_tc();
      chk(cyc - c0 == 10, "R6 new period applied", cyc - c0, 10);

      // R8: two loads in one period, last one wins
      wait_tc();
      load_code(7);
      load_code(6);
      expect_period(8, "R8 last load wins");

      // R7: load in the wrap cycle takes effect immediately
      do begin
         @(posedge clk); #2;
      end while (r_cnt != r_n - 1);
      div_code = 10'd1;
      div_load = 1'b1;
      @(posedge clk); #1;
      c0 = cyc;
      #1 div_load = 1'b0;
      wait_tc();
      chk(cyc - c0 == 2, "R7 load at wrap bypasses", cyc - c0, 2);

      load_code(1023);
      expect_period(1025, "R2 all-ones gives 1025");
      load_code(1022);
      expect_period(1024, "R3 code 1022 gives 1024");
      load_code(4);
      expect_period(6, "R3 code 4 gives 6");

      // R1: reset mid-run returns to ratio 2
      wait_tc();
      @(posedge clk); #2 rst = 1'b1;
      @(posedge clk); @(posedge clk); #2 rst = 1'b0;
      #0.5;
      chk(clk_div_o == 1'b0, "R1 output low after mid-run reset", int'(clk_div_o), 0);
      expect_period(2, "R1 ratio 2 after mid-run reset");

      repeat (4) @(posedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule